// File: doc/BRIEF.md
# Network Board Control and Parity Capture Register Block

This block is the host-facing control logic of a network controller board. The host reaches four 16-bit words through a word-addressed read/write port: a status word, an unused filler word, a parity-control word and a parity-address word. From the status word the block drives the network controller's reset line and its loopback-release line. It also drives the board memory configuration outputs: P2 bus enable, RAM size select and the high RAM address bits. A software-set channel attention bit is turned into a single-cycle pulse to the controller.

The memory path reports parity errors on dedicated inputs: a strobe, the failing address split into a high nibble and a low 16-bit word, the byte half that failed, and the error source. The first error is held with all its details until the host acknowledges it through the parity-control word. A synchronised chip interrupt and the held parity error are each gated by their own enable bit and combined into one host interrupt request.

Two small state machines carry the sequencing. The attention machine has the states ATTN_IDLE, ATTN_PULSE and ATTN_HOLD. Its transitions are: IDLE to PULSE when the attention bit is seen set, PULSE to HOLD while the bit stays set, PULSE to IDLE when the bit is already cleared, and HOLD to IDLE when the bit is cleared. The parity machine has the states PE_IDLE and PE_HELD. It moves from IDLE to HELD on an error strobe, which captures the details. It moves from HELD back to IDLE on an acknowledge. Error strobes that arrive while it is in HELD are ignored.

Top module: `bcr_board_ctl`

## Requirements
- R1: After reset, every output is 0 and all four words read 0 while the chip interrupt input is low.
- R2: Status write bits 15 (reset), 14 (on-air), 13 (attention), 12 (interrupt enable), 11 (parity interrupt enable), 5 (P2 enable), 4 (RAM size) and 3:0 (RAM address bits 20:17) are stored and read back. ctl_reset, ctl_onair, p2_enable, ram_size_sel and ram_addr_hi follow bits 15, 14, 5, 4 and 3:0 from the clock edge of the write.
- R3: Bit 9 (parity flag) and bit 8 (chip interrupt flag) of the status word are read-only. Bits 10, 7 and 6 are unused. Writing any of these bits has no effect, and the unused bits read 0.
- R4: The clock edge after a status write changes bit 13 from 0 to 1, ctl_attn is high for exactly one cycle. Writing bit 13 as 1 again while it is already 1 gives no further pulse.
- R5: Status bit 8 shows chip_irq_in through a two-stage synchroniser, so it follows the input two clock edges later.
- R6: In the idle state, a perr_valid strobe captures the failing address and sets the parity flag (status bit 9). The high nibble is read in parity-control bits 3:0, the low word in the parity-address word, the byte half in parity-control bit 6 and the source in parity-control bit 7.
- R7: While the parity flag is set, later perr_valid strobes leave all captured values unchanged.
- R8: Writing the parity-control word with bit 8 set clears the parity flag and re-arms capture. Bit 8 always reads 0. A parity-control write with bit 8 clear has no effect.
- R9: host_irq = (bit 8 AND bit 12) OR (bit 9 AND bit 11).
- R10: Word index 0 is status, 1 is the filler, 2 is parity control and 3 is parity address. The filler reads 0 and ignores writes, and the parity-address word is read-only. Read data appears on host_rdata on the clock edge that accepts the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_word | input | 2 | Word index |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Registered read data |
| chip_irq_in | input | 1 | Asynchronous chip interrupt |
| perr_valid | input | 1 | Parity error strobe |
| perr_addr_hi | input | 4 | Failing address bits 20:17 |
| perr_addr_lo | input | 16 | Failing address low word |
| perr_lane | input | 1 | Byte half that failed |
| perr_src | input | 1 | Error source |
| ctl_reset | output | 1 | Controller reset |
| ctl_onair | output | 1 | Leave loopback |
| ctl_attn | output | 1 | Channel attention pulse |
| host_irq | output | 1 | Combined interrupt request |
| p2_enable | output | 1 | P2 memory bus enable |
| ram_size_sel | output | 1 | Large RAM select |
| ram_addr_hi | output | 4 | RAM address bits 20:17 |

## Verification
The hardest case to reach is a second parity error that arrives while the first is still held. The capture has to survive it, and capture has to work again once the acknowledge is written. The stimulus raises one error, reads every field back, and injects a second error with every field different. It then writes the parity-control word without bit 8, which must change nothing. Only after that does it write a real acknowledge and inject a third error, which is the one that must be captured. Attention is checked cycle by cycle around a 0-to-1 write and around a repeated write of the bit as 1.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
    localparam int WORD_W   = 16;
    localparam int INDEX_W  = 2;

    typedef enum logic [INDEX_W-1:0] {
        W_STATUS = 2'd0,
        W_FILLER = 2'd1,
        W_PCTL   = 2'd2,
        W_PADDR  = 2'd3
    } word_e;

    // status bit positions
    localparam int SB_RESET = 15;
    localparam int SB_ONAIR = 14;
    localparam int SB_ATTN  = 13;
    localparam int SB_IEN   = 12;
    localparam int SB_PIEN  = 11;
    localparam int SB_PFLAG = 9;
    localparam int SB_CFLAG = 8;
    localparam int SB_P2    = 5;
    localparam int SB_SIZE  = 4;

    // parity-control bit positions
    localparam int PB_ACK   = 8;
    localparam int PB_SRC   = 7;
    localparam int PB_LANE  = 6;

    localparam logic [WORD_W-1:0] STATUS_WMASK = 16'hF83F;

    typedef enum logic [1:0] {
        ATTN_IDLE  = 2'd0,
        ATTN_PULSE = 2'd1,
        ATTN_HOLD  = 2'd2
    } attn_st_e;

    typedef enum logic {
        PE_IDLE = 1'b0,
        PE_HELD = 1'b1
    } pe_st_e;
endpackage

// File: rtl/bcr_sync.sv
module bcr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[i] <= 1'b0;
                    else        stage_q[i] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[i] <= 1'b0;
                    else        stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/bcr_attn_fsm.sv
module bcr_attn_fsm
    import bcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic attn_bit,
    output logic attn_pulse
);
    attn_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ATTN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ATTN_IDLE:  if (attn_bit) state_d = ATTN_PULSE;
            ATTN_PULSE: state_d = attn_bit ? ATTN_HOLD : ATTN_IDLE;
            ATTN_HOLD:  if (!attn_bit) state_d = ATTN_IDLE;
            default:    state_d = ATTN_IDLE;
        endcase
    end

    always_comb begin
        attn_pulse = (state_q == ATTN_PULSE);
    end
endmodule

// File: rtl/bcr_perr_fsm.sv
module bcr_perr_fsm
    import bcr_pkg::*;
#(
    parameter int HI_W = 4,
    parameter int LO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            err_valid,
    input  logic [HI_W-1:0] err_hi,
    input  logic [LO_W-1:0] err_lo,
    input  logic            err_lane,
    input  logic            err_src,
    input  logic            ack,
    output logic            flag,
    output logic [HI_W-1:0] cap_hi,
    output logic [LO_W-1:0] cap_lo,
    output logic            cap_lane,
    output logic            cap_src
);
    pe_st_e state_q, state_d;
    logic   take;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            PE_IDLE: if (err_valid) begin
                state_d = PE_HELD;
                take    = 1'b1;
            end
            PE_HELD: if (ack) state_d = PE_IDLE;
            default: state_d = PE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_hi   <= '0;
            cap_lo   <= '0;
            cap_lane <= 1'b0;
            cap_src  <= 1'b0;
        end else if (take) begin
            cap_hi   <= err_hi;
            cap_lo   <= err_lo;
            cap_lane <= err_lane;
            cap_src  <= err_src;
        end
    end

    always_comb begin
        flag = (state_q == PE_HELD);
    end
endmodule

// File: rtl/bcr_board_ctl.sv
module bcr_board_ctl
    import bcr_pkg::*;
#(
    parameter int HI_W        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_en,
    input  logic                host_we,
    input  logic [INDEX_W-1:0]  host_word,
    input  logic [WORD_W-1:0]   host_wdata,
    output logic [WORD_W-1:0]   host_rdata,
    input  logic                chip_irq_in,
    input  logic                perr_valid,
    input  logic [HI_W-1:0]     perr_addr_hi,
    input  logic [WORD_W-1:0]   perr_addr_lo,
    input  logic                perr_lane,
    input  logic                perr_src,
    output logic                ctl_reset,
    output logic                ctl_onair,
    output logic                ctl_attn,
    output logic                host_irq,
    output logic                p2_enable,
    output logic                ram_size_sel,
    output logic [HI_W-1:0]     ram_addr_hi
);
    localparam int PAD_W = 6 - HI_W;

    logic [WORD_W-1:0] stat_q;
    logic              chip_flag;
    logic              perr_flag;
    logic [HI_W-1:0]   cap_hi;
    logic [WORD_W-1:0] cap_lo;
    logic              cap_lane;
    logic              cap_src;
    logic              wr_stat, wr_pctl, ack;
    logic [WORD_W-1:0] stat_view, pctl_view, rd_mux;

    assign wr_stat = host_en && host_we && (host_word == W_STATUS);
    assign wr_pctl = host_en && host_we && (host_word == W_PCTL);
    assign ack     = wr_pctl && host_wdata[PB_ACK];

    always_ff @(posedge clk) begin
        if (!rst_n)       stat_q <= '0;
        else if (wr_stat) stat_q <= host_wdata & STATUS_WMASK;
    end

    bcr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (chip_irq_in),
        .q_sync  (chip_flag)
    );

    bcr_attn_fsm u_attn (
        .clk        (clk),
        .rst_n      (rst_n),
        .attn_bit   (stat_q[SB_ATTN]),
        .attn_pulse (ctl_attn)
    );

    bcr_perr_fsm #(.HI_W(HI_W), .LO_W(WORD_W)) u_perr (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_valid(perr_valid),
        .err_hi   (perr_addr_hi),
        .err_lo   (perr_addr_lo),
        .err_lane (perr_lane),
        .err_src  (perr_src),
        .ack      (ack),
        .flag     (perr_flag),
        .cap_hi   (cap_hi),
        .cap_lo   (cap_lo),
        .cap_lane (cap_lane),
        .cap_src  (cap_src)
    );

    always_comb begin
        stat_view           = stat_q;
        stat_view[SB_PFLAG] = perr_flag;
        stat_view[SB_CFLAG] = chip_flag;
        pctl_view           = {7'b0, 1'b0, cap_src, cap_lane, {PAD_W{1'b0}}, cap_hi};
    end

    always_comb begin
        rd_mux = '0;
        unique case (host_word)
            W_STATUS: rd_mux = stat_view;
            W_FILLER: rd_mux = '0;
            W_PCTL:   rd_mux = pctl_view;
            W_PADDR:  rd_mux = cap_lo;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                   host_rdata <= '0;
        else if (host_en && !host_we) host_rdata <= rd_mux;
    end

    assign ctl_reset    = stat_q[SB_RESET];
    assign ctl_onair    = stat_q[SB_ONAIR];
    assign p2_enable    = stat_q[SB_P2];
    assign ram_size_sel = stat_q[SB_SIZE];
    assign ram_addr_hi  = stat_q[HI_W-1:0];
    assign host_irq     = (chip_flag && stat_q[SB_IEN]) || (perr_flag && stat_q[SB_PIEN]);
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        host_en,
    input logic        host_we,
    input logic [1:0]  host_word,
    input logic [15:0] host_wdata,
    input logic        ctl_reset,
    input logic        ctl_attn,
    input logic        host_irq,
    input logic        ien_bit,
    input logic        pien_bit,
    input logic        perr_flag,
    input logic        ack,
    input logic [15:0] cap_lo
);
    p_reset_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en && host_we && host_word == 2'd0) |=> (ctl_reset == $past(host_wdata[15])));

    p_attn_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_attn |=> !ctl_attn);

    p_first_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_flag && !ack) |=> $stable(cap_lo));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_flag && ack) |=> !perr_flag);

    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (ien_bit || pien_bit));
endmodule

bind bcr_board_ctl bcr_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_en    (host_en),
    .host_we    (host_we),
    .host_word  (host_word),
    .host_wdata (host_wdata),
    .ctl_reset  (ctl_reset),
    .ctl_attn   (ctl_attn),
    .host_irq   (host_irq),
    .ien_bit    (stat_q[12]),
    .pien_bit   (stat_q[11]),
    .perr_flag  (perr_flag),
    .ack        (ack),
    .cap_lo     (cap_lo)
);

// File: tb/test_bcr_board_ctl.sv
module test_bcr_board_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_en = 1'b0, host_we = 1'b0;
    logic [1:0]  host_word = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        chip_irq_in = 1'b0;
    logic        perr_valid = 1'b0;
    logic [3:0]  perr_addr_hi = '0;
    logic [15:0] perr_addr_lo = '0;
    logic        perr_lane = 1'b0, perr_src = 1'b0;
    logic        ctl_reset, ctl_onair, ctl_attn, host_irq, p2_enable, ram_size_sel;
    logic [3:0]  ram_addr_hi;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    typedef struct { string req; logic [15:0] exp; } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    bcr_board_ctl i_bcr_board_ctl (.*);

    // driver side: push expected item
    task automatic expect_val(input string req, input logic [15:0] exp);
        item_t it;
        it.req = req; it.exp = exp;
        sb_q.push_back(it);
    endtask

    // monitor side: pop and compare
    task automatic observe(input logic [15:0] act);
        item_t it;
        it = sb_q.pop_front();
        tests++;
        if (act !== it.exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
    endtask

    task automatic wr(input logic [1:0] w, input logic [15:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_word = w; host_wdata = d;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] w, input logic [15:0] exp);
        expect_val(req, exp);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_word = w;
        @(negedge clk);
        host_en = 1'b0;
        observe(host_rdata);
    endtask

    task automatic pin_check(input string req, input logic act, input logic exp);
        expect_val(req, {15'b0, exp});
        observe({15'b0, act});
    endtask

    task automatic inject(input logic [3:0] hi, input logic [15:0] lo, input logic lane, input logic src);
        @(negedge clk);
        perr_valid = 1'b1; perr_addr_hi = hi; perr_addr_lo = lo;
        perr_lane = lane; perr_src = src;
        @(negedge clk);
        perr_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        pin_check("R1 ctl_reset", ctl_reset, 1'b0);
        pin_check("R1 host_irq", host_irq, 1'b0);
        pin_check("R1 ctl_attn", ctl_attn, 1'b0);
        rd_check("R1 status", 2'd0, 16'h0000);
        rd_check("R1 pctl", 2'd2, 16'h0000);
        rd_check("R1 paddr", 2'd3, 16'h0000);

        // R2 writable bits (attention kept clear)
        wr(2'd0, 16'hDFFF);
        pin_check("R2 ctl_reset", ctl_reset, 1'b1);
        pin_check("R2 ctl_onair", ctl_onair, 1'b1);
        pin_check("R2 p2_enable", p2_enable, 1'b1);
        pin_check("R2 ram_size_sel", ram_size_sel, 1'b1);
        expect_val("R2 ram_addr_hi", 16'h000F); observe({12'b0, ram_addr_hi});
        rd_check("R2 status readback", 2'd0, 16'hD83F);
        wr(2'd0, 16'h0000);
        pin_check("R2 ctl_reset released", ctl_reset, 1'b0);

        // R3 read-only and unused bits
        wr(2'd0, 16'h07C0);
        rd_check("R3 ro bits ignored", 2'd0, 16'h0000);

        // R10 filler and read-only parity address
        wr(2'd1, 16'hFFFF);
        rd_check("R10 filler", 2'd1, 16'h0000);
        wr(2'd3, 16'hA5A5);
        rd_check("R10 paddr ro", 2'd3, 16'h0000);
        rd_check("R10 status untouched", 2'd0, 16'h0000);

        // R4 attention pulse
        wr(2'd0, 16'h2000);
        pin_check("R4 no pulse yet", ctl_attn, 1'b0);
        @(negedge clk);
        pin_check("R4 pulse", ctl_attn, 1'b1);
        @(negedge clk);
        pin_check("R4 pulse ends", ctl_attn, 1'b0);
        wr(2'd0, 16'h2000);
        for (int i = 0; i < 3; i++) begin
            pin_check("R4 repeat set no pulse", ctl_attn, 1'b0);
            @(negedge clk);
        end
        wr(2'd0, 16'h0000);

        // R5 / R9 chip interrupt path
        wr(2'd0, 16'h1000);
        chip_irq_in = 1'b1;
        @(negedge clk);
        pin_check("R5 one edge not yet", host_irq, 1'b0);
        @(negedge clk);
        pin_check("R5 R9 irq after two edges", host_irq, 1'b1);
        rd_check("R5 flag bit8", 2'd0, 16'h1100);
        wr(2'd0, 16'h0000);
        pin_check("R9 masked", host_irq, 1'b0);
        chip_irq_in = 1'b0;
        repeat (3) @(negedge clk);

        // R6 parity capture
        wr(2'd0, 16'h0800);
        inject(4'h5, 16'hBEEF, 1'b1, 1'b0);
        rd_check("R6 pctl fields", 2'd2, 16'h0045);
        rd_check("R6 paddr", 2'd3, 16'hBEEF);
        rd_check("R6 flag bit9", 2'd0, 16'h0A00);
        pin_check("R9 parity irq", host_irq, 1'b1);

        // R7 later error ignored
        inject(4'hA, 16'h1234, 1'b0, 1'b1);
        rd_check("R7 paddr kept", 2'd3, 16'hBEEF);
        rd_check("R7 pctl kept", 2'd2, 16'h0045);

        // R8 write without ack has no effect, then real ack
        wr(2'd2, 16'h00FF);
        rd_check("R8 no-ack write", 2'd0, 16'h0A00);
        wr(2'd2, 16'h0100);
        rd_check("R8 flag cleared", 2'd0, 16'h0800);
        pin_check("R8 R9 irq dropped", host_irq, 1'b0);
        rd_check("R8 ack reads zero", 2'd2, 16'h0045);
        inject(4'hA, 16'h1234, 1'b0, 1'b1);
        rd_check("R8 rearmed pctl", 2'd2, 16'h008A);
        rd_check("R8 rearmed paddr", 2'd3, 16'h1234);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule